// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating dual-slope converter. It steps the analog front end through a four-phase cycle. The first phase cancels offsets. The second integrates the input for a fixed number of clocks. The third discharges the integrator against a reference of the opposite sign until the comparator reports a zero crossing. The fourth returns the integrator output to zero. The number of clocks spent in the third phase is the magnitude of the conversion result.

The sequencer drives one enable line per analog switch. It samples the input sign from the comparator and uses it to choose the reference direction. It then publishes the magnitude, the sign and an overrange flag together, marked by a single-cycle valid strobe. While `run` is high the cycles repeat back to back. When `run` is low, the block finishes the current cycle and then rests with every switch open.

Top module: `dsadc_seq`

## Requirements
- R1: After reset every switch enable, `result`, `polarity`, `overrange` and `valid` are 0, and while `run` stays low every switch stays off.
- R2: Phases run in the order offset cancel, input integrate, reference discharge, integrator reset, and then offset cancel again while `run` is high. If `run` is low when the integrator-reset phase ends, the block goes idle with all switches off.
- R3: Offset cancel lasts exactly AZ_CYCLES clocks, with `sw_az_loop`, `sw_in_common` and `sw_ref_chg` high and every other switch off.
- R4: Input integrate lasts exactly INT_CYCLES clocks, with only `sw_in_conn` high.
- R5: The input sign is `cmp` sampled on the last input-integrate clock (`cmp`=1 means integrator output above zero). When the sign is 1, discharge uses `sw_ref_neg`; when it is 0, discharge uses `sw_ref_pos`.
- R6: Discharge ends on the first clock at which `cmp` differs from the sampled sign. `result` equals the number of discharge clocks, counting that clock.
- R7: If no crossing occurs within DEINT_MAX discharge clocks, discharge ends, `result` is DEINT_MAX and `overrange` is 1. A crossing on the last allowed clock is in range.
- R8: `result`, `polarity` and `overrange` change together, in the clock after discharge ends, with `valid` high for exactly that one clock.
- R9: Integrator reset drives only `sw_int_zero`. It ends on the first clock at which `int_zero` is high, or after IZ_TIMEOUT clocks, whichever comes first.
- R10: All switches are off for one clock between any two phases, and `sw_ref_pos` and `sw_ref_neg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep converting while high |
| cmp | input | 1 | Comparator: integrator output above zero |
| int_zero | input | 1 | Integrator output detected at zero |
| sw_az_loop | output | 1 | Close offset-cancel feedback loop |
| sw_in_common | output | 1 | Tie internal input nodes to analog common |
| sw_ref_chg | output | 1 | Charge reference capacitor |
| sw_in_conn | output | 1 | Connect external input |
| sw_ref_pos | output | 1 | Apply positive reference |
| sw_ref_neg | output | 1 | Apply negative reference |
| sw_int_zero | output | 1 | Short integrator output to zero |
| result | output | $clog2(DEINT_MAX+1) | Discharge clock count |
| polarity | output | 1 | Input sign, 1 = positive |
| overrange | output | 1 | Discharge hit its limit |
| valid | output | 1 | One-clock strobe for a new result |

## Verification
The assertions assume that `cmp` and `int_zero` are synchronous to `clk` and steady around each rising edge. They also assume that `cmp` can change only while a switch is moving charge. The bench meets both conditions with a clocked integrator model that updates its accumulator and both inputs on the falling edge, using only the switch enables the block drives. As a result, every crossing, sign and zero flag the sequencer sees follows from its own switch activity and the chosen input level.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_AZ    = 3'd1,
        PH_INT   = 3'd2,
        PH_DEINT = 3'd3,
        PH_IZ    = 3'd4,
        PH_GAP   = 3'd5
    } phase_e;

    typedef struct packed {
        logic az_loop;
        logic in_common;
        logic ref_chg;
        logic in_conn;
        logic ref_pos;
        logic ref_neg;
        logic int_zero;
    } sw_t;

    function automatic sw_t sw_decode(input phase_e ph, input logic pos_sign);
        sw_t s;
        s = '0;
        case (ph)
            PH_AZ: begin
                s.az_loop   = 1'b1;
                s.in_common = 1'b1;
                s.ref_chg   = 1'b1;
            end
            PH_INT:   s.in_conn  = 1'b1;
            PH_DEINT: begin
                s.ref_neg = pos_sign;
                s.ref_pos = ~pos_sign;
            end
            PH_IZ:    s.int_zero = 1'b1;
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
    import dsadc_pkg::*;
#(
    parameter int AZ_CYCLES  = 100,
    parameter int INT_CYCLES = 1000,
    parameter int DEINT_MAX  = 2000,
    parameter int IZ_TIMEOUT = 200,
    parameter int RES_W      = $clog2(DEINT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cmp,
    input  logic             int_zero,
    output phase_e           ph_nxt,
    output logic             sign_nxt,
    output logic             sign_cur,
    output logic             done,
    output logic [RES_W-1:0] done_cnt,
    output logic             done_ovr
);

    localparam int MAX_AB = (AZ_CYCLES > INT_CYCLES) ? AZ_CYCLES : INT_CYCLES;
    localparam int MAX_CD = (DEINT_MAX > IZ_TIMEOUT) ? DEINT_MAX : IZ_TIMEOUT;
    localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] AZ_LAST    = CNT_W'(AZ_CYCLES - 1);
    localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(INT_CYCLES - 1);
    localparam logic [CNT_W-1:0] DEINT_LAST = CNT_W'(DEINT_MAX - 1);
    localparam logic [CNT_W-1:0] IZ_LAST    = CNT_W'(IZ_TIMEOUT - 1);

    typedef struct packed {
        phase_e           ph;
        phase_e           tgt;
        logic [CNT_W-1:0] cnt;
        logic             sign;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        done     = 1'b0;
        done_cnt = '0;
        done_ovr = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                s_d.cnt = '0;
                if (run) s_d.ph = PH_AZ;
            end
            PH_AZ: begin
                if (s_q.cnt == AZ_LAST) begin
                    s_d.ph  = PH_GAP;
                    s_d.tgt = PH_INT;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_INT: begin
                if (s_q.cnt == INT_LAST) begin
                    s_d.sign = cmp;
                    s_d.ph   = PH_GAP;
                    s_d.tgt  = PH_DEINT;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_DEINT: begin
                if (cmp != s_q.sign) begin
                    done     = 1'b1;
                    done_cnt = RES_W'(s_q.cnt + 1'b1);
                    s_d.ph   = PH_GAP;
                    s_d.tgt  = PH_IZ;
                    s_d.cnt  = '0;
                end else if (s_q.cnt == DEINT_LAST) begin
                    done     = 1'b1;
                    done_ovr = 1'b1;
                    done_cnt = RES_W'(DEINT_MAX);
                    s_d.ph   = PH_GAP;
                    s_d.tgt  = PH_IZ;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_IZ: begin
                if (int_zero || (s_q.cnt == IZ_LAST)) begin
                    s_d.ph  = PH_GAP;
                    s_d.tgt = PH_AZ;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                s_d.cnt = '0;
                if ((s_q.tgt == PH_AZ) && !run) s_d.ph = PH_IDLE;
                else                             s_d.ph = s_q.tgt;
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ph_nxt   = s_d.ph;
    assign sign_nxt = s_d.sign;
    assign sign_cur = s_q.sign;

    AST_SEQ_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GAP && $past(s_q.ph) == PH_AZ) |=> s_q.ph == PH_INT); // R2
    AST_SEQ_DEINT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GAP && $past(s_q.ph) == PH_INT) |=> s_q.ph == PH_DEINT); // R2
    AST_SEQ_IZ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_GAP && $past(s_q.ph) == PH_DEINT) |=> s_q.ph == PH_IZ); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ph == PH_DEINT |-> s_q.cnt <= DEINT_LAST); // R7
    AST_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_DEINT && $past(s_q.ph) == PH_DEINT) |-> s_q.sign == $past(s_q.sign)); // R5

endmodule

// File: rtl/dsadc_sw_drv.sv
module dsadc_sw_drv
    import dsadc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e ph_nxt,
    input  logic   sign_nxt,
    output sw_t    sw
);

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d = sw_decode(ph_nxt, sign_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_d;
    end

    assign sw = sw_q;

    AST_GAP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q != '0 && $past(sw_q) != '0) |-> sw_q == $past(sw_q)); // R10
    AST_REF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_q.ref_pos && sw_q.ref_neg)); // R10
    AST_INPUT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q.in_conn |-> !(sw_q.in_common || sw_q.ref_pos || sw_q.ref_neg)); // R4

endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
    parameter int DEINT_MAX = 2000,
    parameter int RES_W     = $clog2(DEINT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] cnt_in,
    input  logic             sign_in,
    input  logic             ovr_in,
    output logic [RES_W-1:0] result,
    output logic             polarity,
    output logic             overrange,
    output logic             valid
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             sign;
        logic             ovr;
        logic             vld;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.vld = load;
        if (load) begin
            o_d.res  = cnt_in;
            o_d.sign = sign_in;
            o_d.ovr  = ovr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign result    = o_q.res;
    assign polarity  = o_q.sign;
    assign overrange = o_q.ovr;
    assign valid     = o_q.vld;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.vld |=> !o_q.vld); // R8
    AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.vld && o_q.ovr) |-> o_q.res == RES_W'(DEINT_MAX)); // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.vld |-> $stable(o_q.res)); // R8

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int AZ_CYCLES  = 100,
    parameter int INT_CYCLES = 1000,
    parameter int DEINT_MAX  = 2000,
    parameter int IZ_TIMEOUT = 200
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run,
    input  logic                             cmp,
    input  logic                             int_zero,
    output logic                             sw_az_loop,
    output logic                             sw_in_common,
    output logic                             sw_ref_chg,
    output logic                             sw_in_conn,
    output logic                             sw_ref_pos,
    output logic                             sw_ref_neg,
    output logic                             sw_int_zero,
    output logic [$clog2(DEINT_MAX+1)-1:0]   result,
    output logic                             polarity,
    output logic                             overrange,
    output logic                             valid
);

    localparam int RES_W = $clog2(DEINT_MAX + 1);

    phase_e           ph_nxt;
    logic             sign_nxt;
    logic             sign_cur;
    logic             done;
    logic [RES_W-1:0] done_cnt;
    logic             done_ovr;
    sw_t              sw;

    dsadc_phase_ctrl #(
        .AZ_CYCLES  (AZ_CYCLES),
        .INT_CYCLES (INT_CYCLES),
        .DEINT_MAX  (DEINT_MAX),
        .IZ_TIMEOUT (IZ_TIMEOUT),
        .RES_W      (RES_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cmp      (cmp),
        .int_zero (int_zero),
        .ph_nxt   (ph_nxt),
        .sign_nxt (sign_nxt),
        .sign_cur (sign_cur),
        .done     (done),
        .done_cnt (done_cnt),
        .done_ovr (done_ovr)
    );

    dsadc_sw_drv u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_nxt   (ph_nxt),
        .sign_nxt (sign_nxt),
        .sw       (sw)
    );

    dsadc_result_reg #(
        .DEINT_MAX (DEINT_MAX),
        .RES_W     (RES_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .cnt_in    (done_cnt),
        .sign_in   (sign_cur),
        .ovr_in    (done_ovr),
        .result    (result),
        .polarity  (polarity),
        .overrange (overrange),
        .valid     (valid)
    );

    assign sw_az_loop   = sw.az_loop;
    assign sw_in_common = sw.in_common;
    assign sw_ref_chg   = sw.ref_chg;
    assign sw_in_conn   = sw.in_conn;
    assign sw_ref_pos   = sw.ref_pos;
    assign sw_ref_neg   = sw.ref_neg;
    assign sw_int_zero  = sw.int_zero;

    AST_REF_MATCHES_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ref_neg |-> sign_cur); // R5

endmodule

// File: tb/dsadc_seq_test.sv
module dsadc_seq_test;

    localparam int AZ   = 4;
    localparam int INTC = 20;
    localparam int DMAX = 40;
    localparam int IZTO = 6;
    localparam int VREF = 4;
    localparam int RW   = $clog2(DMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic cmp = 1'b0;
    logic int_zero = 1'b0;
    logic sw_az_loop, sw_in_common, sw_ref_chg, sw_in_conn;
    logic sw_ref_pos, sw_ref_neg, sw_int_zero;
    logic [RW-1:0] result;
    logic polarity, overrange, valid;

    always #5 clk = ~clk;

    dsadc_seq #(
        .AZ_CYCLES (AZ), .INT_CYCLES (INTC), .DEINT_MAX (DMAX), .IZ_TIMEOUT (IZTO)
    ) uut (
        .clk (clk), .rst_n (rst_n), .run (run), .cmp (cmp), .int_zero (int_zero),
        .sw_az_loop (sw_az_loop), .sw_in_common (sw_in_common), .sw_ref_chg (sw_ref_chg),
        .sw_in_conn (sw_in_conn), .sw_ref_pos (sw_ref_pos), .sw_ref_neg (sw_ref_neg),
        .sw_int_zero (sw_int_zero), .result (result), .polarity (polarity),
        .overrange (overrange), .valid (valid)
    );

    int checks = 0;
    int errors = 0;
    int vin_r = 0;
    bit stuck_r = 1'b0;
    int acc = 0;
    int n_valid = 0;

    typedef struct {
        int res;
        bit pol;
        bit ovr;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // integrator model, updated away from the active edge
    always @(negedge clk) begin
        if (!rst_n) acc = 0;
        else begin
            if (sw_in_conn) acc += vin_r;
            if (sw_ref_neg) acc -= VREF;
            if (sw_ref_pos) acc += VREF;
            if (sw_int_zero) acc = 0;
        end
        cmp      = (acc > 0);
        int_zero = stuck_r ? 1'b0 : (acc == 0);
    end

    // monitor: scoreboard, strobe width, gaps and phase order
    logic [6:0] prev_sw = '0;
    int last_code = 0;
    bit prev_valid = 1'b0;
    always @(negedge clk) begin
        logic [6:0] cur;
        int code;
        cur = {sw_az_loop, sw_in_common, sw_ref_chg, sw_in_conn, sw_ref_pos, sw_ref_neg, sw_int_zero};
        if (rst_n) begin
            if (valid) begin
                n_valid++;
                chk(!prev_valid, "R8", "valid wider than one clock", 1, 0);
                if (sb.size() == 0) chk(1'b0, "R8", "valid without pending conversion", 1, 0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(result) == e.res, e.ovr ? "R7" : "R6", "result", int'(result), e.res);
                    chk(polarity == e.pol, "R5", "polarity", int'(polarity), int'(e.pol));
                    chk(overrange == e.ovr, "R7", "overrange", int'(overrange), int'(e.ovr));
                end
            end
            if (cur != prev_sw) begin
                chk(!(prev_sw != 0 && cur != 0), "R10", "switch sets without off clock", int'(cur), 0);
                chk(!(sw_ref_pos && sw_ref_neg), "R10", "both references", 1, 0);
            end
            code = sw_az_loop ? 1 : sw_in_conn ? 2 : (sw_ref_pos | sw_ref_neg) ? 3 : sw_int_zero ? 4 : 0;
            if (code != 0 && code != last_code) begin
                chk(code == (last_code % 4) + 1, "R2", "phase order", code, (last_code % 4) + 1);
                last_code = code;
            end
        end
        prev_sw = cur;
        prev_valid = valid;
    end

    function automatic exp_t expect_of(input int vin);
        exp_t e;
        int a, n;
        a = INTC * vin;
        if (a > 0) begin e.pol = 1'b1; n = (a + VREF - 1) / VREF; end
        else       begin e.pol = 1'b0; n = (-a) / VREF + 1; end
        e.ovr = (n > DMAX);
        e.res = e.ovr ? DMAX : n;
        return e;
    endfunction

    // driver: one full conversion with checks on each phase length
    task automatic conv(input int vin, input bit stuck, input bit drop_run);
        exp_t e;
        int n_az, n_in, n_pos, n_neg, n_iz;
        bit az_ok;
        e = expect_of(vin);
        while (!sw_az_loop) @(negedge clk);
        vin_r = vin;
        stuck_r = stuck;
        sb.push_back(e);
        n_az = 0; az_ok = 1'b1;
        while (sw_az_loop) begin
            n_az++;
            if (!(sw_in_common && sw_ref_chg) || sw_in_conn || sw_ref_pos || sw_ref_neg || sw_int_zero)
                az_ok = 1'b0;
            @(negedge clk);
        end
        chk(n_az == AZ, "R3", "offset cancel length", n_az, AZ);
        chk(az_ok, "R3", "offset cancel switch set", 0, 1);
        if (drop_run) run = 1'b0;
        while (!sw_in_conn) @(negedge clk);
        n_in = 0;
        while (sw_in_conn) begin n_in++; @(negedge clk); end
        chk(n_in == INTC, "R4", "input integrate length", n_in, INTC);
        while (!(sw_ref_pos || sw_ref_neg)) @(negedge clk);
        n_pos = 0; n_neg = 0;
        while (sw_ref_pos || sw_ref_neg) begin
            if (sw_ref_pos) n_pos++;
            if (sw_ref_neg) n_neg++;
            @(negedge clk);
        end
        chk((e.pol ? n_neg : n_pos) == e.res, "R6", "discharge clocks on chosen reference",
            e.pol ? n_neg : n_pos, e.res);
        chk((e.pol ? n_pos : n_neg) == 0, "R5", "wrong reference used", e.pol ? n_pos : n_neg, 0);
        while (!sw_int_zero) @(negedge clk);
        n_iz = 0;
        while (sw_int_zero) begin n_iz++; @(negedge clk); end
        chk(n_iz == (stuck ? IZTO : 1), "R9", "integrator reset length", n_iz, stuck ? IZTO : 1);
        stuck_r = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit quiet;
        repeat (3) @(negedge clk);
        chk({sw_az_loop, sw_in_common, sw_ref_chg, sw_in_conn, sw_ref_pos, sw_ref_neg, sw_int_zero} == 0,
            "R1", "switches in reset", 1, 0);
        chk(result == 0 && !polarity && !overrange && !valid, "R1", "outputs in reset", int'(result), 0);
        rst_n = 1'b1;
        quiet = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if ({sw_az_loop, sw_in_common, sw_ref_chg, sw_in_conn, sw_ref_pos, sw_ref_neg, sw_int_zero} != 0)
                quiet = 1'b0;
        end
        chk(quiet, "R1", "idle with run low", 0, 1);
        run = 1'b1;
        conv(3, 1'b0, 1'b0);
        conv(-3, 1'b0, 1'b0);
        conv(0, 1'b0, 1'b0);
        conv(8, 1'b0, 1'b0);
        conv(9, 1'b0, 1'b0);
        conv(-9, 1'b0, 1'b0);
        conv(1, 1'b1, 1'b0);
        conv(5, 1'b0, 1'b1);
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if ({sw_az_loop, sw_in_common, sw_ref_chg, sw_in_conn, sw_ref_pos, sw_ref_neg, sw_int_zero} != 0)
                quiet = 1'b0;
        end
        chk(quiet, "R2", "idle after run dropped", 0, 1);
        chk(sb.size() == 0, "R8", "pending results left", sb.size(), 0);
        chk(n_valid == 8, "R8", "number of valid strobes", n_valid, 8);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule